// File: doc/BRIEF.md
# Streaming Linear Convolution Engine

This block is a small coprocessor that forms the full linear convolution of two eight-entry sequences of unsigned 8-bit samples, yielding fifteen sums. A host fills the two operand banks one pair per cycle: each accepted word carries one sample for each bank. A single start pulse then launches the computation.

The fifteen sums are not gathered into a wide result array. Each sum leaves the block on a 32-bit result port in the cycle after it is formed, marked by a one-cycle valid pulse. A busy flag stays high over the whole run. Per output index, all eight candidate products are formed in parallel and summed in one step. A four-bit index register walks through the indices, so the block produces one result per clock.

The first operand enters the sum in reversed order. Result k is the sum of first[7-i]*second[j] over every i+j=k, with i and j in 0..7. Samples that fall outside the overlap of the two sequences count as zero.

Top module: `conv_stream`

## Requirements
- R1: While the block is idle and fewer than 8 pairs are held, each cycle with load_i high stores data_i[15:8] as the next entry of the first operand and data_i[7:0] as the next entry of the second operand. Entries fill in order from entry 0 to entry 7.
- R2: A load_i pulse is ignored when 8 pairs are already held or while busy_o is high. The load position returns to entry 0 only when a run completes or on reset. Held operands stay intact across a run.
- R3: A start_i pulse seen while the block is idle makes busy_o high in the next cycle.
- R4: After busy_o rises, res_valid_o is low for one cycle. It then pulses high for exactly 15 consecutive cycles, one for each output index in order 0 to 14, and it is high only while busy_o is high.
- R5: The value on res_o while res_valid_o is high for index k equals the sum over i+j=k (i, j in 0..7) of first[7-i]*second[j], zero-extended to 32 bits. res_o holds its value while no result is being emitted.
- R6: busy_o stays high during the cycle that shows index 14. It is low, with res_valid_o low, in the following cycle.
- R7: A start_i pulse while busy_o is high is ignored. It does not alter the results of the run, and it does not start a new run afterward.
- R8: Asserting rst_ni low asynchronously clears busy_o, res_valid_o, res_o, the load position and both operand banks to zero, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe: store one operand pair from data_i |
| start_i | input | 1 | Start strobe: begin a run when idle |
| data_i | input | 16 | [15:8] first-operand sample, [7:0] second-operand sample |
| res_o | output | 32 | Current convolution sum |
| res_valid_o | output | 1 | One-cycle pulse per emitted sum |
| busy_o | output | 1 | High from the cycle after start through the last emitted sum |

## Verification
The hardest situations to reach from the ports are strobes that arrive at the wrong time. Examples are a ninth load on a full bank, a start pulse in the middle of a run, and a reset that cuts a run short. In each case the block must leave no trace. The stimulus places a second start pulse inside a streaming run and a surplus load after a full bank. It then checks that the streamed sums still match the reference model for the original operands. The bench also drops reset partway through a run and then runs the block with no operands loaded, which shows that the banks and the load position were cleared.

// File: rtl/conv_stream_pkg.sv
package conv_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_operand_store.sv
module conv_operand_store #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   busy_i,
  input  logic                   clear_i,
  input  logic [2*DW-1:0]        data_i,
  output logic [N-1:0][DW-1:0]   a_o,
  output logic [N-1:0][DW-1:0]   b_o
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam int unsigned AW = $clog2(N);

  logic [CW-1:0]         cnt_q;
  logic [N-1:0][DW-1:0]  a_q, b_q;
  logic                  accept;

  assign accept = load_i && !busy_i && (cnt_q < CW'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (accept) begin
      a_q[cnt_q[AW-1:0]] <= data_i[2*DW-1:DW];
      b_q[cnt_q[AW-1:0]] <= data_i[DW-1:0];
      cnt_q              <= cnt_q + CW'(1);
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N)); // R1
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(N) && load_i && !clear_i) |=> ($stable(a_q) && $stable(b_q))); // R2
  AST_BUSY_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clear_i) |=> ($stable(cnt_q) && $stable(a_q) && $stable(b_q))); // R2
endmodule

// File: rtl/conv_dot_unit.sv
module conv_dot_unit #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8
) (
  input  logic [$clog2(2*N-1)-1:0]         idx_i,
  input  logic [N-1:0][DW-1:0]             a_i,
  input  logic [N-1:0][DW-1:0]             b_i,
  output logic [2*DW+$clog2(N)-1:0]        sum_o
);
  localparam int unsigned IW = $clog2(2*N-1);
  localparam int unsigned AW = $clog2(N);
  localparam int unsigned SW = 2*DW + $clog2(N);

  logic [SW-1:0] prod_w [N];

  // lane g pairs first[N-1-g] with second[idx-g]
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [IW:0] j_w;
    logic        hit_w;
    assign j_w   = {1'b0, idx_i} - (IW+1)'(g);
    assign hit_w = (idx_i >= IW'(g)) && (j_w < (IW+1)'(N));
    assign prod_w[g] = hit_w ? (SW'(a_i[N-1-g]) * SW'(b_i[j_w[AW-1:0]])) : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + prod_w[i];
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_stream_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output logic                         busy_o,
  output logic                         emit_o,
  output logic                         clear_o,
  output logic [$clog2(2*N-1)-1:0]     idx_o
);
  localparam int unsigned IW = $clog2(2*N-1);
  localparam logic [IW-1:0] LAST = IW'(2*N-2);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
        end
        ST_RUN: begin
          if (idx_q == LAST) state_q <= ST_DRAIN;
          else               idx_q   <= idx_q + IW'(1);
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign emit_o  = (state_q == ST_RUN);
  assign clear_o = (state_q == ST_DRAIN);
  assign idx_o   = idx_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_RUN && idx_q == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && idx_q != LAST) |=> (state_q == ST_RUN && idx_q == IW'($past(idx_q) + IW'(1)))); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST); // R4
  AST_LAST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && idx_q == LAST) |=> (state_q == ST_DRAIN)); // R6
  AST_DRAIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |=> (state_q == ST_IDLE)); // R6
endmodule

// File: rtl/conv_stream.sv
module conv_stream #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned OW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               start_i,
  input  logic [2*DW-1:0]    data_i,
  output logic [OW-1:0]      res_o,
  output logic               res_valid_o,
  output logic               busy_o
);
  localparam int unsigned IW = $clog2(2*N-1);
  localparam int unsigned SW = 2*DW + $clog2(N);

  logic [N-1:0][DW-1:0] a_w, b_w;
  logic [IW-1:0]        idx_w;
  logic [SW-1:0]        sum_w;
  logic                 busy_w, emit_w, clear_w;
  logic [OW-1:0]        res_q;
  logic                 valid_q;

  conv_sequencer #(.N(N)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_w),
    .emit_o  (emit_w),
    .clear_o (clear_w),
    .idx_o   (idx_w)
  );

  conv_operand_store #(.N(N), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .busy_i  (busy_w),
    .clear_i (clear_w),
    .data_i  (data_i),
    .a_o     (a_w),
    .b_o     (b_w)
  );

  conv_dot_unit #(.N(N), .DW(DW)) u_dot (
    .idx_i (idx_w),
    .a_i   (a_w),
    .b_i   (b_w),
    .sum_o (sum_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit_w;
      if (emit_w) res_q <= OW'(sum_w);
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = valid_q;
  assign busy_o      = busy_w;

  AST_VALID_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o); // R4
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_w |=> $stable(res_q)); // R5
  AST_NO_VALID_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !res_valid_o); // R6
endmodule

// File: tb/sim_conv_stream.sv
module sim_conv_stream;
  localparam int NV = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [31:0] res_o;
  logic        res_valid_o;
  logic        busy_o;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  conv_stream u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .start_i     (start_i),
    .data_i      (data_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .busy_o      (busy_o)
  );

  // entry e of a sequence lives in bits [8*e +: 8]
  localparam logic [63:0] VA [NV] = '{
    64'h02_0B_09_06_08_05_04_01,
    64'h00_00_00_00_00_00_00_00,
    64'hFF_FF_FF_FF_FF_FF_FF_FF,
    64'h3C_A7_11_F0_5E_82_D9_6B,
    64'h01_00_80_FF_7F_00_02_FE
  };
  localparam logic [63:0] VB [NV] = '{
    64'h02_03_13_10_07_09_19_1F,
    64'h00_00_00_00_00_00_00_00,
    64'hFF_FF_FF_FF_FF_FF_FF_FF,
    64'h9E_04_C3_55_2A_E1_70_18,
    64'hFF_01_00_40_FE_00_80_03
  };

  function automatic logic [31:0] model(logic [63:0] a, logic [63:0] b, int k);
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) begin
      int j = k - i;
      if (j >= 0 && j < 8) s += 32'(a[(7-i)*8 +: 8]) * 32'(b[j*8 +: 8]);
    end
    return s;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic load8(logic [63:0] a, logic [63:0] b);
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      load_i = 1'b1;
      data_i = {a[e*8 +: 8], b[e*8 +: 8]};
    end
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // start pulse, then check the streamed sums cycle by cycle
  task automatic run(logic [63:0] a, logic [63:0] b, bit poke_start, bit poke_load);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R3", "busy after start", 32'(busy_o), 32'd1);
    chk("R4", "no valid first cycle", 32'(res_valid_o), 32'd0);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      start_i = poke_start && (k == 5);
      load_i  = poke_load && (k == 7);
      data_i  = 16'hA5A5;
      chk("R4", $sformatf("valid idx %0d", k), 32'(res_valid_o), 32'd1);
      chk("R5", $sformatf("sum idx %0d", k), res_o, model(a, b, k));
      if (k == 14) chk("R6", "busy on last", 32'(busy_o), 32'd1);
    end
    @(negedge clk);
    start_i = 1'b0;
    load_i  = 1'b0;
    chk("R6", "busy dropped", 32'(busy_o), 32'd0);
    chk("R6", "valid dropped", 32'(res_valid_o), 32'd0);
    @(negedge clk);
    chk("R7", "no restart", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset busy", 32'(busy_o), 32'd0);
    chk("R8", "reset valid", 32'(res_valid_o), 32'd0);
    chk("R8", "reset res", res_o, 32'd0);
    rst_ni = 1'b1;

    // table walk: R1 load order, R5 sums, R7 stray start, R2 load while busy
    for (int v = 0; v < NV; v++) begin
      load8(VA[v], VB[v]);
      run(VA[v], VB[v], v == 1, v == 3);
    end
    chk("R5", "sample idx0 literal", model(VA[0], VB[0], 0), 32'h3e);

    // R2: surplus load on a full bank is ignored
    load8(VA[3], VB[3]);
    @(negedge clk);
    load_i = 1'b1;
    data_i = 16'h7777;
    @(negedge clk);
    load_i = 1'b0;
    run(VA[3], VB[3], 1'b0, 1'b0);
    // R2: operands survive a run; restart without reload
    run(VA[3], VB[3], 1'b0, 1'b0);
    // R2: load position restarted at entry 0 after the run
    load8(VA[4], VB[4]);
    run(VA[4], VB[4], 1'b0, 1'b0);

    // R8: reset mid-run
    load8(VA[0], VB[0]);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8", "midrun busy", 32'(busy_o), 32'd0);
    chk("R8", "midrun valid", 32'(res_valid_o), 32'd0);
    chk("R8", "midrun res", res_o, 32'd0);
    rst_ni = 1'b1;
    // R8: banks cleared to zero
    run(64'd0, 64'd0, 1'b0, 1'b0);
    load8(VA[0], VB[0]);
    run(VA[0], VB[0], 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule